// File: doc/BRIEF.md
# Bus-Idle Automatic Power-Down Controller

This block sits between a microcontroller's external bus and a set of on-chip memories and programmable-logic blocks. It watches the controller's address-strobe line and counts clock cycles in which the strobe has not changed. Once the idle count reaches a programmable threshold, and power-down has been enabled by software, the block enters a power-down state. In that state it forces the address and data buses seen by the memories and logic blocks to zero and drives every memory select inactive, so that external bus noise cannot disturb the downstream blocks.

A small register bank holds the enable, the idle threshold, a per-signal mask that keeps chosen inputs from reaching the logic blocks, and a turbo-mode bit that the block exports as a mode output. A separate chip-select input deselects the memories without blocking any signal and without affecting the logic blocks. The first strobe change seen in power-down brings the block back to the active state.

Top module: `idle_pwrdn_ctrl`

## Requirements
- R1: After reset the block is active (`pwrDown`=0), turbo is on (`turboOn`=1), power-down is disabled, the mask is all zero and the threshold register holds `TIMEOUT_RST` (255 by default).
- R2: With enable set, the idle counter clears on the clock edge that acts on a detected strobe change and adds one per clock edge otherwise, saturating at all ones; `pwrDown` rises on the first edge at which the counter is at or above the threshold. A strobe change placed just after an edge therefore raises `pwrDown` on the (threshold+4)th edge after it. With enable clear, `pwrDown` never rises.
- R3: Both a rising and a falling strobe change count as activity; a strobe that toggles more often than the threshold keeps the block active.
- R4: While `pwrDown`=1, `busAddr` and `busData` are all zero whatever `addrIn` and `dataIn` do; while active they equal the inputs.
- R5: While `pwrDown`=1, every bit of `memSel` is 0 (selects are active high).
- R6: When `chipSelIn`=0, `memSel` is all zero while `busAddr`, `busData` and `logicOut` still pass their inputs.
- R7: Mask bit i set to 1 forces `logicOut[i]` to 0; a clear bit lets `logicIn[i]` through. In power-down `logicOut` is all zero.
- R8: Register 0 bit 0 is the turbo bit (1 = turbo on) and drives `turboOn`; register 0 bit 1 is the power-down enable.
- R9: In power-down, a strobe change placed just after an edge clears `pwrDown` on the third edge after it and the buses pass again.
- R10: Register map (2-bit address): 0 control, 1 idle threshold, 2 logic mask (bit i for `logicIn[i]`), 3 status read-only with bit 0 = `pwrDown`. Reads are combinational. Clearing the enable while in power-down clears `pwrDown` one edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| strobeIn | input | 1 | Asynchronous address strobe from the microcontroller |
| chipSelIn | input | 1 | Memory chip select, 0 deselects all memories |
| regWe | input | 1 | Register write enable |
| regAddr | input | 2 | Register address |
| regWdata | input | TW | Register write data |
| regRdata | output | TW | Register read data |
| addrIn | input | AW | Address bus from the microcontroller |
| dataIn | input | DW | Data bus from the microcontroller |
| memSelIn | input | NMEM | Decoded memory selects, active high |
| logicIn | input | NSIG | Signals toward the logic blocks |
| busAddr | output | AW | Gated address toward memories and logic |
| busData | output | DW | Gated data toward memories and logic |
| memSel | output | NMEM | Final memory selects, active high |
| logicOut | output | NSIG | Masked signals toward the logic blocks |
| pwrDown | output | 1 | 1 while in power-down |
| turboOn | output | 1 | Turbo mode output |

## Verification
The bench measures the exact edge on which power-down starts and ends; a counter off by one, or a synchronizer with one stage too few or too many, shifts these edges and is reported. It toggles the strobe just faster than the threshold in both directions, which catches a detector that only sees rising changes, and it runs long idle stretches with the enable clear, which catches entry that ignores the enable. It pairs chip-select low with buses that must still pass and masks with alternating bits, so a chip select that also gates the buses, or a mask applied with inverted sense, shows up as a wrong output value.

// File: rtl/idle_pd_pkg.sv
package idle_pd_pkg;
  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] REG_CTRL    = 2'd0;
  localparam logic [REG_AW-1:0] REG_TIMEOUT = 2'd1;
  localparam logic [REG_AW-1:0] REG_MASK    = 2'd2;
  localparam logic [REG_AW-1:0] REG_STATUS  = 2'd3;

  typedef struct packed {
    logic gateBus;     // zero the buses and logic-block inputs
    logic deselMem;    // force all memory selects inactive
  } pd_strobe_t;
endpackage

// File: rtl/idle_pd_ctrl.sv
module idle_pd_ctrl
  import idle_pd_pkg::*;
#(
  parameter int TW = 16,
  parameter int NSIG = 8,
  parameter int TIMEOUT_RST = 255
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strobeIn,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [TW-1:0]     regWdata,
  output logic [TW-1:0]     regRdata,
  output logic [NSIG-1:0]   blockMask,
  output logic              turboOn,
  output logic              pwrDown,
  output pd_strobe_t        ctlS
);
  localparam int SYNC_N = 3;
  localparam logic [TW-1:0] CNT_MAX = '1;
  localparam logic [TW-1:0] TO_RST = TW'(TIMEOUT_RST);

  logic [SYNC_N-1:0] syncQ;
  logic              actEdge;
  logic [TW-1:0]     idleCnt;
  logic [TW-1:0]     timeoutReg;
  logic              pdEnable;
  logic              turboQ;
  logic [NSIG-1:0]   maskQ;
  logic              pdQ;
  logic [TW-1:0]     maskWide;

  // two synchronizer flops plus one history flop for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_N-2:0], strobeIn};
  end
  assign actEdge = syncQ[SYNC_N-1] ^ syncQ[SYNC_N-2];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      turboQ     <= 1'b1;
      pdEnable   <= 1'b0;
      timeoutReg <= TO_RST;
      maskQ      <= '0;
    end else if (regWe) begin
      case (regAddr)
        REG_CTRL: begin
          turboQ   <= regWdata[0];
          pdEnable <= regWdata[1];
        end
        REG_TIMEOUT: timeoutReg <= regWdata;
        REG_MASK:    maskQ <= regWdata[NSIG-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               idleCnt <= '0;
    else if (actEdge)        idleCnt <= '0;
    else if (idleCnt != CNT_MAX) idleCnt <= idleCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                         pdQ <= 1'b0;
    else if (actEdge || !pdEnable)     pdQ <= 1'b0;
    else if (idleCnt >= timeoutReg)    pdQ <= 1'b1;
  end

  always_comb begin
    maskWide = '0;
    maskWide[NSIG-1:0] = maskQ;
    case (regAddr)
      REG_CTRL:    regRdata = {{(TW-2){1'b0}}, pdEnable, turboQ};
      REG_TIMEOUT: regRdata = timeoutReg;
      REG_MASK:    regRdata = maskWide;
      default:     regRdata = {{(TW-1){1'b0}}, pdQ};
    endcase
  end

  assign blockMask     = maskQ;
  assign turboOn       = turboQ;
  assign pwrDown       = pdQ;
  assign ctlS.gateBus  = pdQ;
  assign ctlS.deselMem = pdQ;
endmodule

// File: rtl/idle_pd_gate.sv
module idle_pd_gate
  import idle_pd_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int NMEM = 3,
  parameter int NSIG = 8
) (
  input  pd_strobe_t      ctlS,
  input  logic            chipSelIn,
  input  logic [NSIG-1:0] blockMask,
  input  logic [AW-1:0]   addrIn,
  input  logic [DW-1:0]   dataIn,
  input  logic [NMEM-1:0] memSelIn,
  input  logic [NSIG-1:0] logicIn,
  output logic [AW-1:0]   busAddr,
  output logic [DW-1:0]   busData,
  output logic [NMEM-1:0] memSel,
  output logic [NSIG-1:0] logicOut
);
  logic memAllow;

  assign busAddr  = ctlS.gateBus ? '0 : addrIn;
  assign busData  = ctlS.gateBus ? '0 : dataIn;
  assign memAllow = chipSelIn && !ctlS.deselMem;

  for (genvar m = 0; m < NMEM; m++) begin : g_sel
    assign memSel[m] = memSelIn[m] && memAllow;
  end

  for (genvar i = 0; i < NSIG; i++) begin : g_blk
    assign logicOut[i] = logicIn[i] && !blockMask[i] && !ctlS.gateBus;
  end
endmodule

// File: rtl/idle_pwrdn_ctrl.sv
module idle_pwrdn_ctrl
  import idle_pd_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int NMEM = 3,
  parameter int NSIG = 8,
  parameter int TW = 16,
  parameter int TIMEOUT_RST = 255
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strobeIn,
  input  logic              chipSelIn,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [TW-1:0]     regWdata,
  output logic [TW-1:0]     regRdata,
  input  logic [AW-1:0]     addrIn,
  input  logic [DW-1:0]     dataIn,
  input  logic [NMEM-1:0]   memSelIn,
  input  logic [NSIG-1:0]   logicIn,
  output logic [AW-1:0]     busAddr,
  output logic [DW-1:0]     busData,
  output logic [NMEM-1:0]   memSel,
  output logic [NSIG-1:0]   logicOut,
  output logic              pwrDown,
  output logic              turboOn
);
  pd_strobe_t      ctlS;
  logic [NSIG-1:0] blockMask;

  idle_pd_ctrl #(.TW(TW), .NSIG(NSIG), .TIMEOUT_RST(TIMEOUT_RST)) u_ctrl (
    .clk(clk), .rstN(rstN), .strobeIn(strobeIn),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .blockMask(blockMask), .turboOn(turboOn), .pwrDown(pwrDown), .ctlS(ctlS)
  );

  idle_pd_gate #(.AW(AW), .DW(DW), .NMEM(NMEM), .NSIG(NSIG)) u_gate (
    .ctlS(ctlS), .chipSelIn(chipSelIn), .blockMask(blockMask),
    .addrIn(addrIn), .dataIn(dataIn), .memSelIn(memSelIn), .logicIn(logicIn),
    .busAddr(busAddr), .busData(busData), .memSel(memSel), .logicOut(logicOut)
  );
endmodule

// File: rtl/idle_pwrdn_chk.sv
module idle_pwrdn_chk #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int NMEM = 3,
  parameter int NSIG = 8,
  parameter int TW = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic            chipSelIn,
  input logic [1:0]      regAddr,
  input logic [TW-1:0]   regRdata,
  input logic [AW-1:0]   busAddr,
  input logic [DW-1:0]   busData,
  input logic [NMEM-1:0] memSel,
  input logic [NSIG-1:0] logicOut,
  input logic [NSIG-1:0] blockMask,
  input logic            pwrDown,
  input logic            actEdge,
  input logic            pdEnable,
  input logic [TW-1:0]   idleCnt
);
  // R2: no entry while disabled
  a_r2_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    !pdEnable |=> !pwrDown);
  // R3: activity restarts the idle count
  a_r3_count_restart: assert property (@(posedge clk) disable iff (!rstN)
    actEdge |=> idleCnt == '0);
  // R4: buses forced to zero in power-down
  a_r4_bus_zero: assert property (@(posedge clk) disable iff (!rstN)
    pwrDown |-> (busAddr == '0 && busData == '0));
  // R5: memory selects off in power-down
  a_r5_sel_off: assert property (@(posedge clk) disable iff (!rstN)
    pwrDown |-> memSel == '0);
  // R6: chip select low deselects memories
  a_r6_cs_desel: assert property (@(posedge clk) disable iff (!rstN)
    !chipSelIn |-> memSel == '0);
  // R7: masked signals read as zero
  a_r7_mask_zero: assert property (@(posedge clk) disable iff (!rstN)
    (logicOut & blockMask) == '0);
  // R9: strobe change in power-down wakes next edge
  a_r9_wake: assert property (@(posedge clk) disable iff (!rstN)
    (pwrDown && actEdge) |=> !pwrDown);
  // R10: status register mirrors power-down state
  a_r10_status: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd3) |-> regRdata[0] == pwrDown);
endmodule

bind idle_pwrdn_ctrl idle_pwrdn_chk #(.AW(AW), .DW(DW), .NMEM(NMEM), .NSIG(NSIG), .TW(TW)) u_chk (
  .clk(clk), .rstN(rstN), .chipSelIn(chipSelIn), .regAddr(regAddr),
  .regRdata(regRdata), .busAddr(busAddr), .busData(busData), .memSel(memSel),
  .logicOut(logicOut), .blockMask(blockMask), .pwrDown(pwrDown),
  .actEdge(u_ctrl.actEdge), .pdEnable(u_ctrl.pdEnable), .idleCnt(u_ctrl.idleCnt)
);

// File: tb/idle_pwrdn_ctrl_tb.sv
`timescale 1ns/1ps
module idle_pwrdn_ctrl_tb;
  localparam int AW = 16, DW = 8, NMEM = 3, NSIG = 8, TW = 16;
  localparam int TO = 10;

  logic clk = 0, rstN = 0, strobeIn = 0, chipSelIn = 1, regWe = 0;
  logic [1:0] regAddr = 0;
  logic [TW-1:0] regWdata = 0, regRdata;
  logic [AW-1:0] addrIn = 0, busAddr;
  logic [DW-1:0] dataIn = 0, busData;
  logic [NMEM-1:0] memSelIn = 0, memSel;
  logic [NSIG-1:0] logicIn = 0, logicOut;
  logic pwrDown, turboOn;
  int nChecks = 0, nErrors = 0;

  always #10 clk = ~clk;

  idle_pwrdn_ctrl u_dut (
    .clk(clk), .rstN(rstN), .strobeIn(strobeIn), .chipSelIn(chipSelIn),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .addrIn(addrIn), .dataIn(dataIn), .memSelIn(memSelIn), .logicIn(logicIn),
    .busAddr(busAddr), .busData(busData), .memSel(memSel), .logicOut(logicOut),
    .pwrDown(pwrDown), .turboOn(turboOn)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [TW-1:0] d);
    regAddr = a; regWdata = d; regWe = 1;
    @(posedge clk); @(negedge clk);
    regWe = 0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [TW-1:0] d);
    regAddr = a; #1; d = regRdata;
  endtask

  task automatic t_reset();
    logic [TW-1:0] v;
    check("R1 pwrDown", pwrDown, 0);
    check("R1 turboOn", turboOn, 1);
    readReg(2'd0, v); check("R1 ctrl reg", v, 1);
    readReg(2'd1, v); check("R1 timeout reg", v, 255);
    readReg(2'd2, v); check("R1 mask reg", v, 0);
    readReg(2'd3, v); check("R10 status reg", v, 0);
    ticks(300);
    check("R2 disabled no entry", pwrDown, 0);
  endtask

  task automatic t_timeout();
    logic [TW-1:0] v;
    writeReg(2'd1, TO);
    writeReg(2'd0, 3);
    strobeIn = ~strobeIn;
    ticks(TO + 3);
    check("R2 not yet down", pwrDown, 0);
    ticks(1);
    check("R2 enters down", pwrDown, 1);
    readReg(2'd3, v); check("R10 status down", v, 1);
  endtask

  task automatic t_gating();
    addrIn = 16'hAAAA; dataIn = 8'h5A; memSelIn = 3'b111; logicIn = 8'hFF; #1;
    check("R4 addr gated", busAddr, 0);
    check("R4 data gated", busData, 0);
    check("R5 sel off", memSel, 0);
    check("R7 logic zero in down", logicOut, 0);
    addrIn = 16'h1234; dataIn = 8'hC3; ticks(2);
    check("R4 addr still gated", busAddr, 0);
    check("R4 data still gated", busData, 0);
  endtask

  task automatic t_wake();
    strobeIn = ~strobeIn;
    ticks(2);
    check("R9 still down", pwrDown, 1);
    ticks(1);
    check("R9 woke", pwrDown, 0);
    check("R4 addr passes", busAddr, 16'h1234);
    check("R4 data passes", busData, 8'hC3);
    check("R5 sel passes", memSel, 3'b111);
    check("R7 logic passes", logicOut, 8'hFF);
  endtask

  task automatic t_activity();
    for (int k = 0; k < 20; k++) begin
      strobeIn = ~strobeIn;
      ticks(TO - 2);
      check("R3 activity keeps active", pwrDown, 0);
    end
  endtask

  task automatic t_chipsel();
    writeReg(2'd0, 1);
    chipSelIn = 0; addrIn = 16'h0F0F; dataIn = 8'h81; logicIn = 8'h3C; #1;
    check("R6 sel off", memSel, 0);
    check("R6 addr passes", busAddr, 16'h0F0F);
    check("R6 data passes", busData, 8'h81);
    check("R6 logic passes", logicOut, 8'h3C);
    chipSelIn = 1; #1;
    check("R6 sel back", memSel, 3'b111);
  endtask

  task automatic t_mask();
    writeReg(2'd2, 16'h00A5);
    logicIn = 8'hFF; #1;
    check("R7 mask A5 on FF", logicOut, 8'h5A);
    logicIn = 8'h0F; #1;
    check("R7 mask A5 on 0F", logicOut, 8'h0A);
    writeReg(2'd2, 16'h0000);
    check("R7 mask cleared", logicOut, 8'h0F);
  endtask

  task automatic t_turbo();
    logic [TW-1:0] v;
    writeReg(2'd0, 0);
    check("R8 turbo off", turboOn, 0);
    readReg(2'd0, v); check("R8 ctrl read", v, 0);
    writeReg(2'd0, 1);
    check("R8 turbo on", turboOn, 1);
  endtask

  task automatic t_disable_exit();
    writeReg(2'd0, 3);
    ticks(TO + 5);
    check("R2 down again", pwrDown, 1);
    writeReg(2'd0, 1);
    check("R10 still down at write edge", pwrDown, 1);
    ticks(1);
    check("R10 disable exits", pwrDown, 0);
  endtask

  initial begin
    #(200000 * 20);
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    ticks(3);
    rstN = 1;
    ticks(1);
    t_reset();
    t_timeout();
    t_gating();
    t_wake();
    t_activity();
    t_chipsel();
    t_mask();
    t_turbo();
    t_disable_exit();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule